// File: doc/BRIEF.md
# Reciprocal Newton-Raphson Refinement Sequencer

This block takes a normalized 53-bit mantissa X (a value from 1 up to but not including 2) and a coarse reciprocal estimate about 14 to 15 bits good. It returns a 53-bit reciprocal good to better than 2^-51. Two Newton-Raphson passes of the form x' = 2x - X*x^2 do the refinement. The block has a single squarer, a single two-stage multiplier and a single subtracter, and both passes share them. A fixed cycle schedule, stepped by a small counter, steers the operand multiplexer and the register enables.

A one-cycle start strobe loads X and the estimate. The refined value appears ten clock edges later, counting the edge that accepted the start, and a one-cycle done pulse marks it. Between passes the working estimate is cut down to the squarer input width. The doubled term is built from the same shortened value, so the cut adds no first-order error. The output is the mantissa of 1/X in the same 1.52 fixed-point form as the input. A divider then needs only one more multiplication by the dividend.

Top module: `nr_recip_refine`

## Requirements
- R1: While reset is high and on the cycle after it, `done_o` is 0 and `recip_o` is all zeros.
- R2: A start accepted at a rising edge loads `mant_i` and `seed_i`. Counting that edge as edge 1, `done_o` goes high after edge 10 for exactly one cycle. It is low after edges 1 through 9.
- R3: The block accepts a start only when idle or in the cycle where `done_o` is high (back-to-back runs). A start seen in any other cycle is ignored: the running operation keeps its operands and timing.
- R4: Each pass computes 2*t - X*t^2. Here t is the estimate truncated to the squarer input, a 1.28 fixed-point value. The seed (1.15 fixed-point) is widened by appending zero bits. The subtracter never underflows.
- R5: The multiplier product X*t^2 is rounded to nearest at weight 2^-56. The final estimate is rounded to nearest at weight 2^-52. `mant_i` encodes X = mant_i/2^52 with bit 52 set, and `recip_o` encodes recip_o/2^52.
- R6: For any X and any seed whose value lies within 2^-14 below 1/X, the result satisfies |recip_o/2^52 - 1/X| < 2^-51.
- R7: For X = 1.0 with a seed of exactly 1.0, `recip_o` equals 2^52 exactly.
- R8: After `done_o`, `recip_o` holds its value while the block stays idle, whatever `mant_i` and `seed_i` do.
- R9: Reset during a run aborts it: no `done_o` pulse follows, and `recip_o` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a refinement |
| mant_i | input | 53 | Mantissa X, 1.52 fixed point, bit 52 set |
| seed_i | input | 16 | Initial reciprocal estimate, 1.15 fixed point |
| recip_o | output | 53 | Refined reciprocal, 1.52 fixed point |
| done_o | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench goes after the operand extremes: X exactly 1 and X just below 2. The first has an exactly representable reciprocal, and a rounding bias would turn 1.0 into 1.0 minus an ulp. The second has a reciprocal near 0.5, where a misplaced binary point or shift halves or doubles the answer. Seeds one unit low test the accuracy margin. A design that doubled the untruncated estimate, or dropped a rounding step, lands 2^-51 or more off there. Starts issued mid-run, back-to-back on the done cycle, and a reset mid-run check the schedule. A counter that restarts, or that fails to restart, shows up as a done pulse that is early, missing or doubled, or as a result computed for the wrong operand.

// File: rtl/nr_pkg.sv
package nr_pkg;

    localparam int unsigned CNT_W       = 4;
    localparam int unsigned STEP_SQ_A   = 2;   // square of seed latched
    localparam int unsigned STEP_SUB_A  = 5;   // first difference latched
    localparam int unsigned STEP_SQ_B   = 6;   // square of first estimate latched
    localparam int unsigned STEP_SUB_B  = 9;   // second difference latched
    localparam int unsigned STEP_LAST   = 10;  // result cycle

    typedef struct packed {
        logic accept;    // start taken this cycle
        logic idle;      // counter at rest
        logic sel_seed;  // operand mux picks the seed
        logic sq_en;     // squarer and held operand update
        logic r_en;      // estimate register update
        logic done;      // result valid
    } nr_strobe_t;

endpackage

// File: rtl/nr_ctrl.sv
module nr_ctrl
    import nr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output nr_strobe_t       stb,
    output logic [CNT_W-1:0] step_o
);

    logic [CNT_W-1:0] step_q;
    logic             at_rest;
    logic             at_last;

    assign at_rest = (step_q == '0);
    assign at_last = (step_q == CNT_W'(STEP_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (start && (at_rest || at_last)) begin
            step_q <= CNT_W'(1);
        end else if (!at_rest && !at_last) begin
            step_q <= step_q + CNT_W'(1);
        end else begin
            step_q <= '0;
        end
    end

    always_comb begin
        stb.accept   = start && (at_rest || at_last);
        stb.idle     = at_rest;
        stb.sel_seed = (step_q == CNT_W'(STEP_SQ_A));
        stb.sq_en    = (step_q == CNT_W'(STEP_SQ_A)) || (step_q == CNT_W'(STEP_SQ_B));
        stb.r_en     = (step_q == CNT_W'(STEP_SUB_A)) || (step_q == CNT_W'(STEP_SUB_B));
        stb.done     = at_last;
    end

    assign step_o = step_q;

    // R2: the result flag lasts a single cycle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        stb.done |=> !stb.done);

    // R2: the result cycle is reached only by stepping from the cycle before it
    assert_done_order_R2: assert property (@(posedge clk) disable iff (rst)
        stb.done |-> ($past(step_q) == CNT_W'(STEP_LAST - 1)));

    // R3: a start inside a run does not disturb the count
    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !at_rest && !at_last) |=> (step_q == $past(step_q) + CNT_W'(1)));

endmodule

// File: rtl/nr_squarer.sv
module nr_squarer #(
    parameter int unsigned IW = 29
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [IW-1:0]   a,
    output logic [2*IW-1:0] q
);

    localparam int unsigned OW = 2 * IW;

    logic [OW-1:0] a_ext;
    assign a_ext = {{IW{1'b0}}, a};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= a_ext * a_ext;
        end
    end

endmodule

// File: rtl/nr_mul2.sv
module nr_mul2 #(
    parameter int unsigned AW = 53,
    parameter int unsigned BW = 58,
    parameter int unsigned SH = 52,
    parameter int unsigned OW = 58
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] p
);

    localparam int unsigned LO = BW / 2;
    localparam int unsigned HI = BW - LO;
    localparam int unsigned FW = AW + BW + 1;

    logic [AW+LO-1:0] pp_lo;
    logic [AW+HI-1:0] pp_hi;
    logic [FW-1:0]    sum;
    logic [FW-1:0]    rnd;

    // first cycle: two partial products over the halves of b
    always_ff @(posedge clk) begin
        if (rst) begin
            pp_lo <= '0;
            pp_hi <= '0;
        end else begin
            pp_lo <= {{LO{1'b0}}, a} * {{AW{1'b0}}, b[LO-1:0]};
            pp_hi <= {{HI{1'b0}}, a} * {{AW{1'b0}}, b[BW-1:LO]};
        end
    end

    assign sum = {{(FW-AW-LO){1'b0}}, pp_lo}
               + ({{(FW-AW-HI){1'b0}}, pp_hi} << LO);

    generate
        if (SH > 0) begin : g_round
            localparam logic [FW-1:0] HALF = {{(FW-1){1'b0}}, 1'b1} << (SH - 1);
            assign rnd = sum + HALF;
        end else begin : g_exact
            assign rnd = sum;
        end
    endgenerate

    // second cycle: accumulate, round to nearest, align
    always_ff @(posedge clk) begin
        if (rst) begin
            p <= '0;
        end else begin
            p <= rnd[SH +: OW];
        end
    end

endmodule

// File: rtl/nr_recip_refine.sv
module nr_recip_refine
    import nr_pkg::*;
#(
    parameter int unsigned MANT_W = 53,
    parameter int unsigned SEED_W = 16,
    parameter int unsigned SQ_W   = 29,
    parameter int unsigned GUARD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic [MANT_W-1:0] recip_o,
    output logic              done_o
);

    localparam int unsigned MF    = MANT_W - 1;       // mantissa fraction bits
    localparam int unsigned SF    = SQ_W - 1;         // squarer input fraction bits
    localparam int unsigned RF    = MF + GUARD;       // working fraction bits
    localparam int unsigned EW    = RF + 2;           // working width, two integer bits
    localparam int unsigned SQO   = 2 * SQ_W;
    localparam int unsigned PSH   = MF + 2 * SF - RF; // product alignment shift
    localparam int unsigned PAD   = SQ_W - SEED_W;
    localparam int unsigned ALIGN = RF - SF;

    nr_strobe_t       stb;
    logic [CNT_W-1:0] step;

    logic [MANT_W-1:0] mant_q;
    logic [SEED_W-1:0] seed_q;
    logic [SQ_W-1:0]   sq_sel;
    logic [SQ_W-1:0]   xt_q;
    logic [SQO-1:0]    sq_q;
    logic [EW-1:0]     pr;
    logic [EW-1:0]     dbl;
    logic [EW-1:0]     r_q;
    logic [EW:0]       fin;

    nr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .stb    (stb),
        .step_o (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mant_q <= '0;
            seed_q <= '0;
        end else if (stb.accept) begin
            mant_q <= mant_i;
            seed_q <= seed_i;
        end
    end

    // operand mux: widened seed on the first pass, truncated estimate on the second
    assign sq_sel = stb.sel_seed ? {seed_q, {PAD{1'b0}}} : r_q[ALIGN +: SQ_W];

    // the squared operand is held so the doubled term matches it exactly
    always_ff @(posedge clk) begin
        if (rst) begin
            xt_q <= '0;
        end else if (stb.sq_en) begin
            xt_q <= sq_sel;
        end
    end

    nr_squarer #(.IW(SQ_W)) u_sq (
        .clk (clk),
        .rst (rst),
        .en  (stb.sq_en),
        .a   (sq_sel),
        .q   (sq_q)
    );

    nr_mul2 #(.AW(MANT_W), .BW(SQO), .SH(PSH), .OW(EW)) u_mul (
        .clk (clk),
        .rst (rst),
        .a   (mant_q),
        .b   (sq_q),
        .p   (pr)
    );

    assign dbl = {xt_q, {(ALIGN + 1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else if (stb.r_en) begin
            r_q <= dbl - pr;
        end
    end

    assign fin     = {1'b0, r_q} + ({{EW{1'b0}}, 1'b1} << (GUARD - 1));
    assign recip_o = fin[GUARD +: MANT_W];
    assign done_o  = stb.done;

    // R4: the doubled estimate always covers the rounded product
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        stb.r_en |-> (dbl >= pr));

    // R8: result held while resting with no request
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stb.idle && !start) |=> $stable(recip_o));

endmodule

// File: tb/sim_nr_recip_refine.sv
`timescale 1ns/1ps
module sim_nr_recip_refine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [52:0] mant = '0;
    logic [15:0] seed = '0;
    logic [52:0] recip;
    logic        done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    localparam int NV = 9;
    localparam logic [52:0] VEC [NV] = '{
        53'h10000000000000, 53'h1FFFFFFFFFFFFF, 53'h18000000000000,
        53'h10000000000001, 53'h1AAAAAAAAAAAAB, 53'h16A09E667F3BCD,
        53'h1921FB54442D18, 53'h1FFFF000000001, 53'h13333333333333
    };

    always #2.5 clk = ~clk;

    nr_recip_refine u0 (
        .clk (clk), .rst (rst), .start (start),
        .mant_i (mant), .seed_i (seed),
        .recip_o (recip), .done_o (done)
    );

    function automatic logic [15:0] seed_of(input logic [52:0] m);
        logic [127:0] q;
        q = (128'd1 << 67) / {75'd0, m};
        return q[15:0];
    endfunction

    function automatic logic [127:0] exact_of(input logic [52:0] m);
        return (128'd1 << 104) / {75'd0, m};
    endfunction

    function automatic bit close(input logic [52:0] y, input logic [52:0] m);
        logic [127:0] p, t, d;
        p = {75'd0, y} * {75'd0, m};
        t = 128'd1 << 104;
        d = (p > t) ? p - t : t - p;
        return d < ({75'd0, m} << 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [52:0] m, input logic [15:0] s);
        mant  = m;
        seed  = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // from a negedge just after the accepting edge: step 1
    task automatic finish_run(input logic [52:0] m, input string req);
        repeat (8) @(negedge clk);
        chk(done == 1'b0, "R2 low at step 9", {127'd0, done}, 128'd0);
        @(negedge clk);
        chk(done == 1'b1, "R2 high at step 10", {127'd0, done}, 128'd1);
        chk(close(recip, m), req, {75'd0, recip}, exact_of(m));
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [52:0] held;
        bit seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", {127'd0, done}, 128'd0);
        chk(recip == '0, "R1 recip in reset", {75'd0, recip}, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && recip == '0, "R1 after reset", {75'd0, recip}, 128'd0);

        // R6, R5, R4: table of operands with a truncated seed
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i], seed_of(VEC[i]));
            finish_run(VEC[i], "R6 accuracy");
            @(negedge clk);
            chk(done == 1'b0, "R2 single pulse", {127'd0, done}, 128'd0);
        end

        // R7: exact unity
        launch(VEC[0], 16'h8000);
        finish_run(VEC[0], "R7 unity");
        chk(recip == 53'h10000000000000, "R7 exact", {75'd0, recip}, 128'h10000000000000);

        // R6: seed one unit low, worst case margin
        for (int i = 1; i < NV; i++) begin
            launch(VEC[i], seed_of(VEC[i]) - 16'd1);
            finish_run(VEC[i], "R6 low seed");
        end

        // R3: start in mid-run ignored, then back-to-back on done
        @(negedge clk);
        launch(VEC[2], seed_of(VEC[2]));
        repeat (2) @(negedge clk);
        mant = VEC[6];
        seed = seed_of(VEC[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b0, "R3 no early done", {127'd0, done}, 128'd0);
        @(negedge clk);
        chk(done == 1'b1, "R3 done on time", {127'd0, done}, 128'd1);
        chk(close(recip, VEC[2]), "R3 first operand kept", {75'd0, recip}, exact_of(VEC[2]));
        launch(VEC[4], seed_of(VEC[4]));
        finish_run(VEC[4], "R3 back-to-back");

        // R8: idle hold with changing inputs
        held = recip;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            mant = VEC[k % NV];
            seed = 16'(k * 977);
            @(negedge clk);
        end
        chk(recip == held && done == 1'b0, "R8 hold while idle", {75'd0, recip}, {75'd0, held});

        // R9: reset mid-run
        launch(VEC[5], seed_of(VEC[5]));
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(recip == '0 && done == 1'b0, "R9 cleared", {75'd0, recip}, 128'd0);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(!seen, "R9 no done after abort", {127'd0, seen}, 128'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule